// File: doc/BRIEF.md
# Chainable Timer Cell Output Controller

This block is the event and output-control stage of one cell in a chain of timer cells. It turns a local event strobe from the cell's capture/compare core into an action on the cell output pin. That action can be hold, toggle, force low or force high. The cell can also take an action that the preceding cell reports on a two-line link, and it forwards actions to the next cell on a two-line link of its own. A cell can therefore follow a neighbour, drive a neighbour, or both.

A small control register sets the cell's behaviour. It holds the action mode and a link-listen bit. It also holds a bypass bit, which makes the outgoing link repeat only neighbour actions. A wake-on-link bit keeps the cell dormant until the first link action arrives. A line-mode bit selects whether the input line produces events on rising edges or on a high level. A timer-mode strobe clears the bypass and wake-on-link bits. Two status outputs report the registered level of the select input and whether the cell currently accepts local events.

Top module: `tcell_outctl`

## Requirements
- R1: With no link action accepted, a local event applies the two low mode bits to `cell_out` at the next clock edge: 00 holds, 01 toggles, 10 drives 0, 11 drives 1.
- R2: With mode bit 2 set, a nonzero `link_in` code (01 toggle, 10 drive 0, 11 drive 1; 00 means none) is applied to `cell_out` at the next edge. When both a link action and a local event occur in the same cycle, the link action takes priority.
- R3: With mode bit 2 clear, `link_in` is ignored: it changes neither `cell_out` nor `link_out`, and it does not wake the cell.
- R4: `link_out` is registered and carries a code for one cycle after the event. With bypass 0 it carries the accepted link code, or else the local action code of an enabled local event. With bypass 1 it carries only the accepted link code. In all other cycles it is 00.
- R5: While wake-on-link is set, local events have no effect and `stat_en` is 0. An accepted link action clears wake-on-link, so `stat_en` reads 1 one cycle later.
- R6: A `timer_clr` strobe clears bypass and wake-on-link at the next edge. This overrides a configuration write in the same cycle.
- R7: In edge mode (`cfg_level` = 0), each rising edge of `in_line` gives exactly one `in_evt` pulse, one cycle after the edge is sampled. While `full_speed` is 1, edge mode gives no events.
- R8: In level mode, `in_evt` equals `in_line` delayed by one cycle, whatever the value of `full_speed`.
- R9: `stat_sel_lvl` equals `sel_in` delayed by one cycle.
- R10: A synchronous reset clears `cell_out`, `link_out`, `in_evt`, both status outputs and all control bits, so `stat_en` reads 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_mode | input | 3 | Action code [1:0] and link-listen bit [2] |
| cfg_bypass | input | 1 | Bypass bit for the link output |
| cfg_wait_link | input | 1 | Wake-on-link bit |
| cfg_level | input | 1 | Input line mode: 0 edge, 1 level |
| timer_clr | input | 1 | Switch-to-timer-mode strobe |
| loc_evt | input | 1 | Local event strobe from the core |
| in_line | input | 1 | Input line for the event generator |
| full_speed | input | 1 | Input clock is the full-speed module clock |
| sel_in | input | 1 | Select input |
| link_in | input | 2 | Action code from the preceding cell |
| cell_out | output | 1 | Cell output pin |
| link_out | output | 2 | Action code to the next cell |
| in_evt | output | 1 | Input line event strobe |
| stat_sel_lvl | output | 1 | Registered select input level |
| stat_en | output | 1 | Cell currently enabled for local events |

## Verification
Every output of this block comes from a register, so each result is due one clock edge after the inputs that cause it. This holds for the output action, the link code, the event strobe and both status bits. A control write or timer-mode strobe changes behaviour starting with the events of the following cycle. The bench drives inputs on the falling edge. It advances its reference model at the rising edge from the inputs held at that edge, and compares all outputs on the next falling edge. Every check therefore looks exactly one edge after its cause.

// File: rtl/tcell_pkg.sv
package tcell_pkg;
  localparam int CODE_W = 2;

  localparam logic [CODE_W-1:0] ACT_NONE = 2'b00;
  localparam logic [CODE_W-1:0] ACT_TOG  = 2'b01;
  localparam logic [CODE_W-1:0] ACT_CLR  = 2'b10;
  localparam logic [CODE_W-1:0] ACT_SET  = 2'b11;

  typedef struct packed {
    logic              lvl;
    logic              wait_link;
    logic              bypass;
    logic              listen;
    logic [CODE_W-1:0] code;
  } tcell_cfg_t;

  function automatic logic apply_code(input logic cur, input logic [CODE_W-1:0] c);
    case (c)
      ACT_TOG: apply_code = ~cur;
      ACT_CLR: apply_code = 1'b0;
      ACT_SET: apply_code = 1'b1;
      default: apply_code = cur;
    endcase
  endfunction
endpackage

// File: rtl/tcell_ctl.sv
module tcell_ctl
  import tcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  tcell_cfg_t wcfg,
  input  logic       tmr_clr,
  input  logic       link_hit,
  input  logic       sel_in,
  output tcell_cfg_t cfg,
  output logic       sel_lvl
);
  tcell_cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg;
    if (we) cfg_n = wcfg;
    if (link_hit) cfg_n.wait_link = 1'b0;
    if (tmr_clr) begin
      cfg_n.wait_link = 1'b0;
      cfg_n.bypass    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      sel_lvl <= 1'b0;
    end else begin
      cfg     <= cfg_n;
      sel_lvl <= sel_in;
    end
  end

  AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> (!cfg.bypass && !cfg.wait_link)); // R6
  AST_LINK_WAKES: assert property (@(posedge clk) disable iff (rst)
    link_hit |=> !cfg.wait_link); // R5
endmodule

// File: rtl/tcell_act.sv
module tcell_act
  import tcell_pkg::*;
#(
  parameter logic OUT_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  tcell_cfg_t        cfg,
  input  logic              loc_evt,
  input  logic [CODE_W-1:0] link_in,
  output logic              link_hit,
  output logic              cell_out,
  output logic [CODE_W-1:0] link_out
);
  logic loc_act;
  logic out_n;
  logic [CODE_W-1:0] lnk_n;

  assign link_hit = cfg.listen && (link_in != ACT_NONE);
  assign loc_act  = loc_evt && !cfg.wait_link;

  always_comb begin
    out_n = cell_out;
    lnk_n = ACT_NONE;
    if (link_hit) begin
      out_n = apply_code(cell_out, link_in);
      lnk_n = link_in;
    end else if (loc_act) begin
      out_n = apply_code(cell_out, cfg.code);
      if (!cfg.bypass) lnk_n = cfg.code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_out <= OUT_RST;
      link_out <= ACT_NONE;
    end else begin
      cell_out <= out_n;
      link_out <= lnk_n;
    end
  end

  AST_DEAF_LINK: assert property (@(posedge clk) disable iff (rst)
    (!cfg.listen && !loc_evt) |=> ($stable(cell_out) && link_out == ACT_NONE)); // R3
  AST_LINK_SET: assert property (@(posedge clk) disable iff (rst)
    (cfg.listen && link_in == ACT_SET) |=> cell_out); // R2
  AST_LINK_CLR: assert property (@(posedge clk) disable iff (rst)
    (cfg.listen && link_in == ACT_CLR) |=> !cell_out); // R2
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg.bypass && (!cfg.listen || link_in == ACT_NONE)) |=> link_out == ACT_NONE); // R4
  AST_DORMANT: assert property (@(posedge clk) disable iff (rst)
    (cfg.wait_link && !link_hit) |=> $stable(cell_out)); // R5
endmodule

// File: rtl/tcell_inevt.sv
module tcell_inevt (
  input  logic clk,
  input  logic rst,
  input  logic lvl_mode,
  input  logic full_speed,
  input  logic in_line,
  output logic evt
);
  logic prev;
  logic evt_n;

  always_comb begin
    if (lvl_mode) evt_n = in_line;
    else          evt_n = in_line && !prev && !full_speed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      evt  <= 1'b0;
    end else begin
      prev <= in_line;
      evt  <= evt_n;
    end
  end

  AST_EDGE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && !in_line) |=> !evt); // R7
  AST_EDGE_FAST: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && full_speed) |=> !evt); // R7
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    lvl_mode |=> (evt == $past(in_line))); // R8
endmodule

// File: rtl/tcell_outctl.sv
module tcell_outctl
  import tcell_pkg::*;
#(
  parameter logic OUT_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_bypass,
  input  logic       cfg_wait_link,
  input  logic       cfg_level,
  input  logic       timer_clr,
  input  logic       loc_evt,
  input  logic       in_line,
  input  logic       full_speed,
  input  logic       sel_in,
  input  logic [1:0] link_in,
  output logic       cell_out,
  output logic [1:0] link_out,
  output logic       in_evt,
  output logic       stat_sel_lvl,
  output logic       stat_en
);
  tcell_cfg_t wcfg;
  tcell_cfg_t cfg;
  logic       link_hit;

  always_comb begin
    wcfg.lvl       = cfg_level;
    wcfg.wait_link = cfg_wait_link;
    wcfg.bypass    = cfg_bypass;
    wcfg.listen    = cfg_mode[2];
    wcfg.code      = cfg_mode[1:0];
  end

  tcell_ctl u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .wcfg(wcfg), .tmr_clr(timer_clr),
    .link_hit(link_hit), .sel_in(sel_in), .cfg(cfg), .sel_lvl(stat_sel_lvl)
  );

  tcell_act #(.OUT_RST(OUT_RST)) u_act (
    .clk(clk), .rst(rst), .cfg(cfg), .loc_evt(loc_evt), .link_in(link_in),
    .link_hit(link_hit), .cell_out(cell_out), .link_out(link_out)
  );

  tcell_inevt u_inevt (
    .clk(clk), .rst(rst), .lvl_mode(cfg.lvl), .full_speed(full_speed),
    .in_line(in_line), .evt(in_evt)
  );

  assign stat_en = !cfg.wait_link;

  AST_SEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_sel_lvl == $past(sel_in))); // R9
  AST_DORMANT_NOFWD: assert property (@(posedge clk) disable iff (rst)
    (!stat_en && !(cfg_mode[2] === 1'bx) && !link_hit) |=> link_out == 2'b00); // R5
endmodule

// File: tb/tcell_outctl_bench.sv
module tcell_outctl_bench;
  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_bypass, cfg_wait_link, cfg_level, timer_clr;
  logic [2:0] cfg_mode;
  logic loc_evt, in_line, full_speed, sel_in;
  logic [1:0] link_in;
  logic cell_out, in_evt, stat_sel_lvl, stat_en;
  logic [1:0] link_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic m_out, m_evt, m_sel, m_prev, m_eoa, m_byp, m_lvl;
  logic [2:0] m_mode;
  logic [1:0] m_link;

  always #2.5 clk = ~clk;

  tcell_outctl u_tcell_outctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_bypass(cfg_bypass), .cfg_wait_link(cfg_wait_link), .cfg_level(cfg_level),
    .timer_clr(timer_clr), .loc_evt(loc_evt), .in_line(in_line),
    .full_speed(full_speed), .sel_in(sel_in), .link_in(link_in),
    .cell_out(cell_out), .link_out(link_out), .in_evt(in_evt),
    .stat_sel_lvl(stat_sel_lvl), .stat_en(stat_en)
  );

  function automatic logic act_of(input logic cur, input logic [1:0] c);
    case (c)
      2'b01: act_of = ~cur;
      2'b10: act_of = 1'b0;
      2'b11: act_of = 1'b1;
      default: act_of = cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_out = 0; m_link = 0; m_evt = 0; m_sel = 0; m_prev = 0;
      m_eoa = 0; m_byp = 0; m_lvl = 0; m_mode = 0;
    end else begin
      logic lhit, lact;
      lhit = m_mode[2] && (link_in != 2'b00);
      lact = loc_evt && !m_eoa;
      if (lhit) begin
        m_out = act_of(m_out, link_in); m_link = link_in;
      end else if (lact) begin
        m_out = act_of(m_out, m_mode[1:0]); m_link = m_byp ? 2'b00 : m_mode[1:0];
      end else m_link = 2'b00;
      m_evt = m_lvl ? in_line : (in_line && !m_prev && !full_speed);
      m_prev = in_line;
      m_sel = sel_in;
      if (cfg_we) begin
        m_mode = cfg_mode; m_byp = cfg_bypass; m_eoa = cfg_wait_link; m_lvl = cfg_level;
      end
      if (lhit) m_eoa = 0;
      if (timer_clr) begin m_eoa = 0; m_byp = 0; end
    end
  end

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2/R3 cell_out", {1'b0, cell_out}, {1'b0, m_out});
    chk("R4 link_out", link_out, m_link);
    chk("R7/R8 in_evt", {1'b0, in_evt}, {1'b0, m_evt});
    chk("R9 stat_sel_lvl", {1'b0, stat_sel_lvl}, {1'b0, m_sel});
    chk("R5/R6 stat_en", {1'b0, stat_en}, {1'b0, !m_eoa});
  endtask

  task automatic idle();
    cfg_we = 0; timer_clr = 0; loc_evt = 0; link_in = 0; in_line = 0;
    sel_in = 0; full_speed = 0;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [2:0] md, input logic byp, input logic wt, input logic lv);
    cfg_we = 1; cfg_mode = md; cfg_bypass = byp; cfg_wait_link = wt; cfg_level = lv;
    step();
    cfg_we = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1; idle();
    cfg_mode = 0; cfg_bypass = 0; cfg_wait_link = 0; cfg_level = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 cell_out", {1'b0, cell_out}, 2'b00);
    chk("R10 link_out", link_out, 2'b00);
    chk("R10 in_evt", {1'b0, in_evt}, 2'b00);
    chk("R10 stat_en", {1'b0, stat_en}, 2'b01);
    rst = 0;
    step();

    // R1: local force 1 then toggle
    wr(3'b011, 0, 0, 0);
    loc_evt = 1; step(); loc_evt = 0;
    chk("R1 force1", {1'b0, cell_out}, 2'b01);
    chk("R4 local code fwd", link_out, 2'b11);
    // R2: link force 0 beats local force 1
    wr(3'b111, 0, 0, 0);
    loc_evt = 1; link_in = 2'b10; step(); loc_evt = 0; link_in = 0;
    chk("R2 link priority", {1'b0, cell_out}, 2'b00);
    // R3: not listening, link ignored
    wr(3'b001, 0, 1, 0);
    link_in = 2'b11; step(); link_in = 0;
    chk("R3 link ignored out", {1'b0, cell_out}, 2'b00);
    chk("R3 link ignored fwd", link_out, 2'b00);
    chk("R3 still dormant", {1'b0, stat_en}, 2'b00);
    // R5: dormant ignores local
    loc_evt = 1; step(); loc_evt = 0;
    chk("R5 dormant", {1'b0, cell_out}, 2'b00);
    // R6: timer clear wakes and clears bypass
    wr(3'b011, 1, 1, 0);
    timer_clr = 1; step(); timer_clr = 0;
    chk("R6 woke", {1'b0, stat_en}, 2'b01);
    loc_evt = 1; step(); loc_evt = 0;
    chk("R6 bypass cleared", link_out, 2'b11);
    // R7: full speed edge mode gives nothing
    full_speed = 1; in_line = 1; step(); step();
    chk("R7 full speed", {1'b0, in_evt}, 2'b00);
    in_line = 0; full_speed = 0; step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      cfg_we = ($urandom % 12) == 0;
      cfg_mode = 3'($urandom); cfg_bypass = 1'($urandom);
      cfg_wait_link = ($urandom % 3) == 0; cfg_level = 1'($urandom);
      timer_clr = ($urandom % 25) == 0;
      loc_evt = ($urandom % 3) == 0;
      link_in = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 4) == 0) in_line = ~in_line;
      if (($urandom % 40) == 0) full_speed = ~full_speed;
      sel_in = 1'($urandom);
      step();
    end
    idle();
    rst = 1; step(); rst = 0;
    chk("R10 late reset", {1'b0, stat_en}, 2'b01);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule